// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a RISC integer unit that uses overlapping register windows and banked globals. Software sees 32 architectural registers at any time: eight globals taken from the bank picked by a global-level register, and three groups of eight (outs, locals, ins) taken from the window picked by the current window pointer. The outs of one window are the same physical storage as the ins of the next window, so a procedure call can pass arguments without copying.

The block keeps the window pointer, the count of windows that can still be saved, and the count of windows that can be restored. A one-cycle window move (save or restore) or a level change is requested on a 2-bit operation input. A save or restore that the counters do not allow is refused: the block raises an overflow or underflow flag for that cycle and changes no state. Another unit handles spills and fills. Two asynchronous read ports and one write port use 5-bit architectural register numbers. An optional field of check bits is stored with every register and moves with it.

Top module: `winreg_file`

## Requirements
- R1: Register numbers 0-7 select globals of the current level, 8-15 the outs, 16-23 the locals and 24-31 the ins of the current window. A value written on the write port appears on both read ports for that register number from the next cycle onward.
- R2: Register 0 reads as zero data and zero check bits on both ports, and a write to it is discarded.
- R3: The outs of window w are the ins of window w+1. When w is the last window (NWIN-1), they are the ins of window 0.
- R4: Operation code 1 (save) with cansave non-zero sets cwp to cwp+1 (0 after NWIN-1), decrements cansave (wrapping 0 to NWIN-1) and increments canrestore (wrapping NWIN-1 to 0).
- R5: Operation code 2 (restore) with canrestore non-zero sets cwp to cwp-1 (NWIN-1 after 0), increments cansave (wrapping NWIN-1 to 0) and decrements canrestore (wrapping 0 to NWIN-1).
- R6: After a save the new window's ins hold the old window's outs. The locals and ins of a window are intact when a later restore returns to it.
- R7: A save requested while cansave is 0 drives ovf_o high in that cycle and leaves cwp, cansave and canrestore unchanged.
- R8: A restore requested while canrestore is 0 drives unf_o high in that cycle and leaves cwp, cansave and canrestore unchanged.
- R9: Operation code 3 loads the global level from lvl_i, clamped to NLVL-1. Each level has its own 8 globals, and a bank's values are visible again when its level is selected again. Code 0 is idle.
- R10: With CHK_EN set, the check bits written with a register are returned with that register's data on every later read, across saves, restores and level changes.
- R11: A write issued in the same cycle as a window move or level change lands in the register as mapped before the move.
- R12: After reset, cwp is NWIN-1, cansave is NWIN-2, canrestore is 0, the level is 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | 0 idle, 1 save, 2 restore, 3 set level |
| lvl_i | input | clog2(NLVL) | New global level for operation 3 |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Architectural register to write |
| wr_data_i | input | DW | Write data |
| wr_chk_i | input | CBW | Write check bits |
| rd0_addr_i | input | 5 | Read port 0 register number |
| rd0_data_o | output | DW | Read port 0 data |
| rd0_chk_o | output | CBW | Read port 0 check bits |
| rd1_addr_i | input | 5 | Read port 1 register number |
| rd1_data_o | output | DW | Read port 1 data |
| rd1_chk_o | output | CBW | Read port 1 check bits |
| cwp_o | output | clog2(NWIN) | Current window pointer |
| cansave_o | output | clog2(NWIN) | Windows available to save |
| canrestore_o | output | clog2(NWIN) | Windows available to restore |
| lvl_o | output | clog2(NLVL) | Current global level |
| ovf_o | output | 1 | Save refused this cycle |
| unf_o | output | 1 | Restore refused this cycle |

## Verification
The assertions assume that the two counters change only through save and restore, so their sum stays at NWIN-2 from reset on. They also assume that op_i holds idle during reset, so the first comparison against a previous value sees reset state. The stimulus drives every operation at the falling edge and returns op_i to idle after each rising edge. It never forces the counters, and it starts the write-readback pattern only on cycles with no window move. Level values sent on lvl_i are always within range, so the clamp is never the reason a check passes.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    WOP_IDLE    = 2'd0,
    WOP_SAVE    = 2'd1,
    WOP_RESTORE = 2'd2,
    WOP_SETLVL  = 2'd3
  } wop_e;

  localparam int SLOTS_PER_WIN = 16;
  localparam int GLOB_PER_LVL  = 8;
  localparam int NUM_RPORTS    = 2;
endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NLVL = 8,
  localparam int WPW = $clog2(NWIN),
  localparam int LW  = $clog2(NLVL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  wop_e           op,
  input  logic [LW-1:0]  lvl_in,
  output logic [WPW-1:0] cwp,
  output logic [WPW-1:0] csv,
  output logic [WPW-1:0] crs,
  output logic [LW-1:0]  lvl,
  output logic           ovf,
  output logic           unf
);
  localparam logic [WPW-1:0] MAXW  = WPW'(NWIN - 1);
  localparam logic [WPW-1:0] ONE_W = WPW'(1);
  localparam logic [LW-1:0]  MAXL  = LW'(NLVL - 1);

  logic [WPW-1:0] cwp_n, csv_n, crs_n;
  logic [LW-1:0]  lvl_n;
  logic           save_ok, rest_ok, lvl_set, upd;

  always_comb begin
    save_ok = (op == WOP_SAVE)    && (csv != '0);
    rest_ok = (op == WOP_RESTORE) && (crs != '0);
    lvl_set = (op == WOP_SETLVL);
    ovf     = (op == WOP_SAVE)    && (csv == '0);
    unf     = (op == WOP_RESTORE) && (crs == '0);
    upd     = save_ok || rest_ok || lvl_set;
  end

  always_comb begin
    cwp_n = cwp;
    csv_n = csv;
    crs_n = crs;
    lvl_n = lvl;
    if (save_ok) begin
      cwp_n = (cwp == MAXW) ? '0 : cwp + ONE_W;
      csv_n = (csv == '0) ? MAXW : csv - ONE_W;
      crs_n = (crs == MAXW) ? '0 : crs + ONE_W;
    end else if (rest_ok) begin
      cwp_n = (cwp == '0) ? MAXW : cwp - ONE_W;
      csv_n = (csv == MAXW) ? '0 : csv + ONE_W;
      crs_n = (crs == '0) ? MAXW : crs - ONE_W;
    end else if (lvl_set) begin
      lvl_n = (lvl_in > MAXL) ? MAXL : lvl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= MAXW;
      csv <= MAXW - ONE_W;
      crs <= '0;
      lvl <= '0;
    end else if (upd) begin
      cwp <= cwp_n;
      csv <= csv_n;
      crs <= crs_n;
      lvl <= lvl_n;
    end
  end

  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ($stable(cwp) && $stable(csv) && $stable(crs)));

  assert_unf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> ($stable(cwp) && $stable(csv) && $stable(crs)));

  assert_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(csv) + int'(crs)) == (NWIN - 2));

  assert_save_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == WOP_SAVE && !ovf) |=>
      (cwp == (($past(cwp) == MAXW) ? '0 : $past(cwp) + ONE_W)));

  assert_rest_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == WOP_RESTORE && !unf) |=>
      (cwp == (($past(cwp) == '0) ? MAXW : $past(cwp) - ONE_W)));

  assert_lvl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op != WOP_SETLVL) |=> $stable(lvl));
endmodule

// File: rtl/wrf_map.sv
module wrf_map
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NLVL = 8,
  parameter int IW   = 8,
  localparam int WPW = $clog2(NWIN),
  localparam int LW  = $clog2(NLVL)
) (
  input  logic [4:0]     addr,
  input  logic [WPW-1:0] cwp,
  input  logic [LW-1:0]  lvl,
  output logic [IW-1:0]  idx
);
  localparam logic [WPW-1:0] MAXW  = WPW'(NWIN - 1);
  localparam logic [WPW-1:0] ONE_W = WPW'(1);
  localparam logic [IW-1:0]  GBASE = IW'(NWIN * SLOTS_PER_WIN);

  logic [WPW-1:0] nxt;

  always_comb begin
    nxt = (cwp == MAXW) ? '0 : cwp + ONE_W;
    case (addr[4:3])
      2'd0:    idx = GBASE + IW'({lvl, addr[2:0]});
      2'd1:    idx = IW'({nxt, 1'b1, addr[2:0]});
      2'd2:    idx = IW'({cwp, 1'b0, addr[2:0]});
      default: idx = IW'({cwp, 1'b1, addr[2:0]});
    endcase
  end
endmodule

// File: rtl/wrf_store.sv
module wrf_store
  import wrf_pkg::*;
#(
  parameter int DEPTH  = 192,
  parameter int IW     = 8,
  parameter int DW     = 32,
  parameter int CBW    = 4,
  parameter bit CHK_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [DW-1:0]             wdata,
  input  logic [CBW-1:0]            wchk,
  input  logic [NUM_RPORTS-1:0][IW-1:0]  ridx,
  output logic [NUM_RPORTS-1:0][DW-1:0]  rdata,
  output logic [NUM_RPORTS-1:0][CBW-1:0] rchk
);
  logic [DW-1:0] dmem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) dmem[widx] <= wdata;
  end

  for (genvar p = 0; p < NUM_RPORTS; p++) begin : g_rd
    assign rdata[p] = dmem[ridx[p]];
  end

  if (CHK_EN) begin : g_chk
    logic [CBW-1:0] cmem [DEPTH];
    always_ff @(posedge clk) begin
      if (we) cmem[widx] <= wchk;
    end
    for (genvar p = 0; p < NUM_RPORTS; p++) begin : g_crd
      assign rchk[p] = cmem[ridx[p]];
    end
  end else begin : g_nochk
    logic unused_chk;
    assign unused_chk = ^wchk;
    assign rchk = '0;
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import wrf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int NLVL   = 8,
  parameter int DW     = 32,
  parameter int CBW    = 4,
  parameter bit CHK_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              op_i,
  input  logic [$clog2(NLVL)-1:0] lvl_i,
  input  logic                    wr_en_i,
  input  logic [4:0]              wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [CBW-1:0]          wr_chk_i,
  input  logic [4:0]              rd0_addr_i,
  output logic [DW-1:0]           rd0_data_o,
  output logic [CBW-1:0]          rd0_chk_o,
  input  logic [4:0]              rd1_addr_i,
  output logic [DW-1:0]           rd1_data_o,
  output logic [CBW-1:0]          rd1_chk_o,
  output logic [$clog2(NWIN)-1:0] cwp_o,
  output logic [$clog2(NWIN)-1:0] cansave_o,
  output logic [$clog2(NWIN)-1:0] canrestore_o,
  output logic [$clog2(NLVL)-1:0] lvl_o,
  output logic                    ovf_o,
  output logic                    unf_o
);
  localparam int WPW   = $clog2(NWIN);
  localparam int LW    = $clog2(NLVL);
  localparam int DEPTH = NWIN * SLOTS_PER_WIN + NLVL * GLOB_PER_LVL;
  localparam int IW    = $clog2(DEPTH);
  localparam int NMAP  = NUM_RPORTS + 1;

  wop_e            op;
  logic [WPW-1:0]  cwp, csv, crs;
  logic [LW-1:0]   lvl;
  logic            we_eff;
  logic [4:0]      map_addr [NMAP];
  logic [IW-1:0]   map_idx  [NMAP];
  logic [NUM_RPORTS-1:0][IW-1:0]  ridx;
  logic [NUM_RPORTS-1:0][DW-1:0]  rdata;
  logic [NUM_RPORTS-1:0][CBW-1:0] rchk;
  logic [4:0]      raddr [NUM_RPORTS];

  assign op = wop_e'(op_i);

  wrf_ctrl #(.NWIN(NWIN), .NLVL(NLVL)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .op(op), .lvl_in(lvl_i),
    .cwp(cwp), .csv(csv), .crs(crs), .lvl(lvl),
    .ovf(ovf_o), .unf(unf_o)
  );

  assign raddr[0] = rd0_addr_i;
  assign raddr[1] = rd1_addr_i;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    if (m < NUM_RPORTS) begin : g_r
      assign map_addr[m] = raddr[m];
      assign ridx[m]     = map_idx[m];
    end else begin : g_w
      assign map_addr[m] = wr_addr_i;
    end
    wrf_map #(.NWIN(NWIN), .NLVL(NLVL), .IW(IW)) map_i (
      .addr(map_addr[m]), .cwp(cwp), .lvl(lvl), .idx(map_idx[m])
    );
  end

  assign we_eff = wr_en_i && (wr_addr_i != 5'd0);

  wrf_store #(.DEPTH(DEPTH), .IW(IW), .DW(DW), .CBW(CBW), .CHK_EN(CHK_EN)) store_i (
    .clk(clk), .we(we_eff), .widx(map_idx[NUM_RPORTS]),
    .wdata(wr_data_i), .wchk(wr_chk_i),
    .ridx(ridx), .rdata(rdata), .rchk(rchk)
  );

  always_comb begin
    rd0_data_o = (rd0_addr_i == 5'd0) ? '0 : rdata[0];
    rd0_chk_o  = (rd0_addr_i == 5'd0) ? '0 : rchk[0];
    rd1_data_o = (rd1_addr_i == 5'd0) ? '0 : rdata[1];
    rd1_chk_o  = (rd1_addr_i == 5'd0) ? '0 : rchk[1];
  end

  assign cwp_o        = cwp;
  assign cansave_o    = csv;
  assign canrestore_o = crs;
  assign lvl_o        = lvl;

  assert_wr_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i != 5'd0 && op == WOP_IDLE) |=>
      ((rd0_addr_i != $past(wr_addr_i)) || (rd0_data_o == $past(wr_data_i))));

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));
endmodule

// File: tb/winreg_file_tb_top.sv
`timescale 1ns/1ps
module winreg_file_tb_top;
  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  lv;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [31:0] ex;
  } row_t;

  localparam int NROW = 17;
  // R1 R2 R3 R5 R6 R9 R10 R11 covered by these rows
  localparam row_t TBL [NROW] = '{
    '{2'd0, 3'd0, 1'b1, 5'd1,  32'h11,   5'd1,  32'h11},   // R1 global
    '{2'd0, 3'd0, 1'b1, 5'd0,  32'hDEAD, 5'd0,  32'h0},    // R2 r0
    '{2'd0, 3'd0, 1'b1, 5'd8,  32'h80,   5'd8,  32'h80},   // R1 out
    '{2'd0, 3'd0, 1'b1, 5'd16, 32'h160,  5'd16, 32'h160},  // R1 local
    '{2'd0, 3'd0, 1'b1, 5'd24, 32'h240,  5'd24, 32'h240},  // R1 in
    '{2'd1, 3'd0, 1'b0, 5'd0,  32'h0,    5'd24, 32'h80},   // R3 R6 save wraps 7->0
    '{2'd0, 3'd0, 1'b1, 5'd16, 32'h1601, 5'd16, 32'h1601}, // R1
    '{2'd0, 3'd0, 1'b1, 5'd8,  32'h81,   5'd8,  32'h81},   // R1
    '{2'd2, 3'd0, 1'b0, 5'd0,  32'h0,    5'd8,  32'h80},   // R3 R5 restore
    '{2'd0, 3'd0, 1'b0, 5'd0,  32'h0,    5'd16, 32'h160},  // R6
    '{2'd0, 3'd0, 1'b0, 5'd0,  32'h0,    5'd24, 32'h240},  // R6
    '{2'd3, 3'd3, 1'b1, 5'd1,  32'h99,   5'd0,  32'h0},    // R11 write with level change
    '{2'd0, 3'd0, 1'b1, 5'd1,  32'h31,   5'd1,  32'h31},   // R9
    '{2'd3, 3'd0, 1'b0, 5'd0,  32'h0,    5'd1,  32'h99},   // R9 R11
    '{2'd3, 3'd3, 1'b0, 5'd0,  32'h0,    5'd1,  32'h31},   // R9
    '{2'd1, 3'd0, 1'b1, 5'd16, 32'h1602, 5'd16, 32'h1601}, // R11 write with save
    '{2'd2, 3'd0, 1'b0, 5'd0,  32'h0,    5'd16, 32'h1602}  // R11 R10
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op_i;
  logic [2:0]  lvl_i;
  logic        wr_en_i;
  logic [4:0]  wr_addr_i, rd0_addr_i, rd1_addr_i;
  logic [31:0] wr_data_i, rd0_data_o, rd1_data_o;
  logic [3:0]  wr_chk_i, rd0_chk_o, rd1_chk_o;
  logic [2:0]  cwp_o, cansave_o, canrestore_o, lvl_o;
  logic        ovf_o, unf_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  winreg_file dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lvl_i(lvl_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wr_chk_i(wr_chk_i),
    .rd0_addr_i(rd0_addr_i), .rd0_data_o(rd0_data_o), .rd0_chk_o(rd0_chk_o),
    .rd1_addr_i(rd1_addr_i), .rd1_data_o(rd1_data_o), .rd1_chk_o(rd1_chk_o),
    .cwp_o(cwp_o), .cansave_o(cansave_o), .canrestore_o(canrestore_o), .lvl_o(lvl_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  function automatic logic [3:0] chk_of(input logic [31:0] d);
    return d[3:0] ^ d[7:4];
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic apply(input logic [1:0] op, input logic [2:0] lv, input logic we,
                       input logic [4:0] wa, input logic [31:0] wd);
    @(negedge clk);
    op_i = op; lvl_i = lv; wr_en_i = we; wr_addr_i = wa;
    wr_data_i = wd; wr_chk_i = chk_of(wd);
    @(posedge clk);
    #2;
    op_i = 2'd0; wr_en_i = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [4:0] ra, input logic [31:0] ex);
    rd0_addr_i = ra; rd1_addr_i = ra;
    #1;
    check(req, "rd0 data", rd0_data_o, ex);
    check(req, "rd0 chk", {28'd0, rd0_chk_o}, {28'd0, chk_of(ex)});
    check(req, "rd1 data", rd1_data_o, ex);
  endtask

  task automatic state_chk(input string req, input int cw, input int cs, input int cr);
    check(req, "cwp", {29'd0, cwp_o}, 32'(cw));
    check(req, "cansave", {29'd0, cansave_o}, 32'(cs));
    check(req, "canrestore", {29'd0, canrestore_o}, 32'(cr));
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog (all R tags) actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_i = 2'd0; lvl_i = 3'd0; wr_en_i = 1'b0; wr_addr_i = 5'd0;
    wr_data_i = 32'd0; wr_chk_i = 4'd0; rd0_addr_i = 5'd0; rd1_addr_i = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    state_chk("R12", 7, 6, 0);
    check("R12", "lvl", {29'd0, lvl_o}, 32'd0);
    check("R12", "ovf", {31'd0, ovf_o}, 32'd0);
    check("R12", "unf", {31'd0, unf_o}, 32'd0);
    check("R2", "r0 after reset", rd0_data_o, 32'd0);

    for (int i = 0; i < NROW; i++) begin
      apply(TBL[i].op, TBL[i].lv, TBL[i].we, TBL[i].wa, TBL[i].wd);
      read_chk("R1/R3/R6/R9/R10/R11 table", TBL[i].ra, TBL[i].ex);
    end
    state_chk("R5", 7, 6, 0);
    check("R9", "lvl after table", {29'd0, lvl_o}, 32'd3);

    // R8 underflow: refused restore
    @(negedge clk);
    op_i = 2'd2;
    #1;
    check("R8", "unf", {31'd0, unf_o}, 32'd1);
    check("R8", "ovf", {31'd0, ovf_o}, 32'd0);
    @(posedge clk);
    #2;
    op_i = 2'd0;
    state_chk("R8", 7, 6, 0);

    // R4 saves down to cansave 0
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      op_i = 2'd1;
      #1;
      check("R4", "ovf low", {31'd0, ovf_o}, 32'd0);
      @(posedge clk);
      #2;
      op_i = 2'd0;
      state_chk("R4", (7 + k) % 8, 6 - k, k);
    end

    // R7 overflow: refused save
    @(negedge clk);
    op_i = 2'd1;
    #1;
    check("R7", "ovf", {31'd0, ovf_o}, 32'd1);
    @(posedge clk);
    #2;
    op_i = 2'd0;
    state_chk("R7", 5, 0, 6);

    // R5 restores back to window 7
    for (int k = 1; k <= 6; k++) begin
      apply(2'd2, 3'd0, 1'b0, 5'd0, 32'd0);
      state_chk("R5", (13 - k) % 8, k, 6 - k);
    end

    // R6 window 7 contents intact after the trip
    read_chk("R6", 5'd16, 32'h1602);
    read_chk("R6", 5'd24, 32'h240);
    // R3 outs of window 7 still alias ins of window 0
    read_chk("R3", 5'd8, 32'h80);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule